// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block runs once after every reset and fetches the two words a processor needs before it can run any code. It first reads the word at the bottom of the vector area and loads it, with its two lowest bits cleared, as the main stack pointer. It then reads the next word, which holds the entry address of the reset handler. That word must have bit 0 set, because bit 0 marks the compact instruction state. The program counter takes the word with bit 0 cleared, and the block reports that it is done.

If bit 0 of the entry word is 0, the block stops in a fault state instead and reports a fault. The mode/control output always starts as privileged thread mode on the main stack.

Memory is reached through a single word-wide read port with a level request and a one-cycle valid strobe. At most one read is in flight at any time. A fresh reset, applied at any point, clears every output and starts the sequence again.

Top module: `boot_vec_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `msp`, `pc`, `mode_ctrl`, `boot_done`, `boot_fault` and `mem_req` all at zero.
- R2: In the first cycle after reset is released, `mem_req` is low. From the second cycle, `mem_req` is high with `mem_addr` = 0x00000000. When `mem_valid` is accepted for this read, `msp` takes `mem_rdata` with bits [1:0] forced to 0 from the next cycle.
- R3: Once the stack word has been accepted, the next request goes to `mem_addr` = 0x00000004. Each request stays high with a stable address until `mem_valid` is seen, and only one address is requested at a time.
- R4: If the entry word has bit 0 = 1, then from the cycle after it is accepted, `pc` equals the word with bit 0 cleared (0x00000101 gives 0x00000100), `boot_done` is 1 and `mem_req` is 0.
- R5: If the entry word has bit 0 = 0, then from the cycle after it is accepted, `boot_fault` is 1, `boot_done` is 0, `pc` stays 0 and `msp` keeps the loaded stack value.
- R6: `mode_ctrl` reads 2'b00 after reset and after completion. Bit 0 = 0 means privileged and bit 1 = 0 means the main stack.
- R7: `mem_valid` has no effect while no request is outstanding, that is, in the idle cycle after reset and in the done and fault states. `msp` and `pc` are unchanged afterwards.
- R8: Reset asserted in any state clears all outputs, even when it coincides with an accepted `mem_valid`. After reset is released, the two reads start again from 0x00000000.
- R9: `boot_done` and `boot_fault` are never high together, and each stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | ADDR_W (32) | Byte address of the requested word |
| mem_valid | input | 1 | Read data strobe, completes the current request |
| mem_rdata | input | DATA_W (32) | Read data |
| msp | output | DATA_W (32) | Main stack pointer, word aligned |
| pc | output | DATA_W (32) | Program counter, bit 0 cleared |
| mode_ctrl | output | 2 | Bit 0: 0 privileged; bit 1: 0 main stack |
| boot_done | output | 1 | Both vectors loaded with a valid entry |
| boot_fault | output | 1 | Entry word had bit 0 clear |

## Verification
Two events can fall in the same clock edge: a reset and the acceptance of the entry word. The bench provokes this by driving `rst` high in the same cycle as a `mem_valid` carrying a good entry word. It then judges that, in the next cycle, `pc` is 0 and neither `boot_done` nor `boot_fault` is set. Stack and entry words, and the wait before each valid, come from a seeded `$urandom`, including zero-wait responses. These are mixed with directed entry words that differ only in bit 0 and with stray valid strobes outside a read.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    BV_IDLE  = 3'd0,
    BV_RD_SP = 3'd1,
    BV_RD_PC = 3'd2,
    BV_DONE  = 3'd3,
    BV_FAULT = 3'd4
  } bv_state_e;

  // Mode/control word at start-up: privileged thread mode, main stack
  localparam logic [1:0] BV_CTRL_START = 2'b00;

endpackage

// File: rtl/boot_vec_fsm.sv
module boot_vec_fsm
  import boot_vec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_valid,
  input  logic      entry_lsb,
  output bv_state_e state,
  output logic      sp_fire,
  output logic      pc_accept,
  output logic      pc_reject,
  output logic      done,
  output logic      fault
);

  bv_state_e state_q, state_d;

  // Named events for the datapath and the assertions
  assign sp_fire   = (state_q == BV_RD_SP) && rd_valid;
  assign pc_accept = (state_q == BV_RD_PC) && rd_valid && entry_lsb;
  assign pc_reject = (state_q == BV_RD_PC) && rd_valid && !entry_lsb;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BV_IDLE:  state_d = BV_RD_SP;
      BV_RD_SP: if (sp_fire) state_d = BV_RD_PC;
      BV_RD_PC: begin
        if (pc_accept)      state_d = BV_DONE;
        else if (pc_reject) state_d = BV_FAULT;
      end
      BV_DONE:  state_d = BV_DONE;
      BV_FAULT: state_d = BV_FAULT;
      default:  state_d = BV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= BV_IDLE;
    else     state_q <= state_d;
  end

  assign state = state_q;
  assign done  = (state_q == BV_DONE);
  assign fault = (state_q == BV_FAULT);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault && !done);

  // R3
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == BV_RD_PC) |-> $past(state_q == BV_RD_SP) || $past(state_q == BV_RD_PC));

endmodule

// File: rtl/boot_vec_port.sv
module boot_vec_port
  import boot_vec_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0000,
  parameter int          WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  bv_state_e         state,
  input  logic              rd_valid,
  output logic              req,
  output logic [ADDR_W-1:0] addr
);

  // Byte address of vector slot n
  function automatic logic [ADDR_W-1:0] slot_addr(input int unsigned n);
    logic [ADDR_W-1:0] base;
    base = ADDR_W'(VEC_BASE);
    return base + ADDR_W'(n * WORD_BYTES);
  endfunction

  localparam logic [ADDR_W-1:0] SP_ADDR = slot_addr(0);
  localparam logic [ADDR_W-1:0] PC_ADDR = slot_addr(1);

  always_comb begin
    req  = 1'b0;
    addr = '0;
    case (state)
      BV_RD_SP: begin req = 1'b1; addr = SP_ADDR; end
      BV_RD_PC: begin req = 1'b1; addr = PC_ADDR; end
      default:  begin req = 1'b0; addr = '0;      end
    endcase
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req && !rd_valid |=> req && $stable(addr));

  // R3
  sp_to_pc_chk: assert property (@(posedge clk) disable iff (rst)
    req && rd_valid && (addr == SP_ADDR) |=> req && (addr == PC_ADDR));

endmodule

// File: rtl/boot_vec_regs.sv
module boot_vec_regs
  import boot_vec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sp_fire,
  input  logic              pc_accept,
  input  logic              pc_reject,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] msp,
  output logic [DATA_W-1:0] pc,
  output logic [1:0]        ctrl
);

  localparam logic [DATA_W-1:0] SP_MASK = ~DATA_W'((1 << ALIGN_BITS) - 1);

  // Force word alignment on the stack pointer
  function automatic logic [DATA_W-1:0] align_sp(input logic [DATA_W-1:0] w);
    return w & SP_MASK;
  endfunction

  // Drop the instruction-state marker from the entry address
  function automatic logic [DATA_W-1:0] entry_to_pc(input logic [DATA_W-1:0] w);
    return {w[DATA_W-1:1], 1'b0};
  endfunction

  logic [DATA_W-1:0] msp_q, pc_q;
  logic [1:0]        ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      msp_q  <= '0;
      pc_q   <= '0;
      ctrl_q <= 2'b00;
    end else begin
      if (sp_fire) begin
        msp_q  <= align_sp(rd_data);
        ctrl_q <= BV_CTRL_START;
      end
      if (pc_accept) pc_q <= entry_to_pc(rd_data);
    end
  end

  assign msp  = msp_q;
  assign pc   = pc_q;
  assign ctrl = ctrl_q;

  // R5
  reject_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    pc_reject |=> (pc_q == '0) && $stable(msp_q));

  // R2
  sp_low_chk: assert property (@(posedge clk) disable iff (rst)
    sp_fire |=> (msp_q[ALIGN_BITS-1:0] == '0) &&
                (msp_q[DATA_W-1:ALIGN_BITS] == $past(rd_data[DATA_W-1:ALIGN_BITS])));

endmodule

// File: rtl/boot_vec_seq.sv
module boot_vec_seq
  import boot_vec_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] msp,
  output logic [DATA_W-1:0] pc,
  output logic [1:0]        mode_ctrl,
  output logic              boot_done,
  output logic              boot_fault
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);

  bv_state_e state;
  logic      sp_fire, pc_accept, pc_reject;

  boot_vec_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (mem_valid),
    .entry_lsb (mem_rdata[0]),
    .state     (state),
    .sp_fire   (sp_fire),
    .pc_accept (pc_accept),
    .pc_reject (pc_reject),
    .done      (boot_done),
    .fault     (boot_fault)
  );

  boot_vec_port #(
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .WORD_BYTES (WORD_BYTES)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .rd_valid (mem_valid),
    .req      (mem_req),
    .addr     (mem_addr)
  );

  boot_vec_regs #(
    .DATA_W     (DATA_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sp_fire   (sp_fire),
    .pc_accept (pc_accept),
    .pc_reject (pc_reject),
    .rd_data   (mem_rdata),
    .msp       (msp),
    .pc        (pc),
    .ctrl      (mode_ctrl)
  );

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_done) |-> $past(mem_valid) && $past(mem_rdata[0]) && !mem_req && (pc[0] == 1'b0));

  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_fault) |-> $past(mem_valid) && !$past(mem_rdata[0]) && !boot_done);

  // R7
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> $stable(msp) && $stable(pc));

  // R6
  ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done |-> (mode_ctrl == BV_CTRL_START));

endmodule

// File: tb/boot_vec_seq_tb.sv
module boot_vec_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] msp, pc;
  logic [1:0]  mode_ctrl;
  logic        boot_done, boot_fault;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  boot_vec_seq u_dut (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .msp(msp), .pc(pc), .mode_ctrl(mode_ctrl),
    .boot_done(boot_done), .boot_fault(boot_fault)
  );

  function automatic logic [31:0] want_sp(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [31:0] want_pc(input logic [31:0] w);
    return w - {31'd0, w[0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check_cleared(input string tag);
    chk({tag, " msp"}, 64'(msp), 64'd0);
    chk({tag, " pc"}, 64'(pc), 64'd0);
    chk({tag, " ctrl"}, 64'(mode_ctrl), 64'd0);
    chk({tag, " done/fault/req"}, {61'd0, boot_done, boot_fault, mem_req}, 64'd0);
  endtask

  // One boot sequence; rst_on_pc applies reset on the same edge as the entry word
  task automatic run_boot(input logic [31:0] sp_w, input logic [31:0] pc_w,
                          input int lat_sp, input int lat_pc, input bit rst_on_pc);
    @(negedge clk);
    rst = 1'b1; mem_valid = 1'b0;
    @(negedge clk);
    check_cleared("R1 reset");
    // release reset with a stray valid in the idle cycle
    rst = 1'b0; mem_valid = 1'b1; mem_rdata = $urandom;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R7 idle valid msp", 64'(msp), 64'd0);
    chk("R2 sp req", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h0000_0000});
    for (int i = 0; i < lat_sp; i++) begin
      @(negedge clk);
      chk("R3 sp hold", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h0000_0000});
    end
    mem_valid = 1'b1; mem_rdata = sp_w;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R2 msp load", 64'(msp), 64'(want_sp(sp_w)));
    chk("R3 pc req", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h0000_0004});
    for (int i = 0; i < lat_pc; i++) begin
      @(negedge clk);
      chk("R3 pc hold", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h0000_0004});
    end
    mem_valid = 1'b1; mem_rdata = pc_w;
    if (rst_on_pc) rst = 1'b1;
    @(negedge clk);
    mem_valid = 1'b0;
    if (rst_on_pc) begin
      check_cleared("R8 reset with valid");
      rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R8 restart req", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h0000_0000});
      return;
    end
    if (pc_w[0]) begin
      chk("R4 pc", 64'(pc), 64'(want_pc(pc_w)));
      chk("R4 done/fault/req", {61'd0, boot_done, boot_fault, mem_req}, {61'd0, 3'b100});
      chk("R6 ctrl", 64'(mode_ctrl), 64'd0);
    end else begin
      chk("R5 pc", 64'(pc), 64'd0);
      chk("R5 msp kept", 64'(msp), 64'(want_sp(sp_w)));
      chk("R5 done/fault/req", {61'd0, boot_done, boot_fault, mem_req}, {61'd0, 3'b010});
    end
    // stray valid strobes after the end
    for (int i = 0; i < 2; i++) begin
      mem_valid = 1'b1; mem_rdata = $urandom;
      @(negedge clk);
    end
    mem_valid = 1'b0;
    @(negedge clk);
    chk("R7 late valid msp", 64'(msp), 64'(want_sp(sp_w)));
    chk("R7 late valid pc", 64'(pc), pc_w[0] ? 64'(want_pc(pc_w)) : 64'd0);
    chk("R9 held", {62'd0, boot_done, boot_fault}, pc_w[0] ? 64'd2 : 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // directed corners
    run_boot(32'h4000_0000, 32'h0000_0101, 0, 0, 1'b0);  // R4 example value
    run_boot(32'h2000_0FFF, 32'h0000_0100, 1, 2, 1'b0);  // R5 bit0 clear
    run_boot(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 0, 1'b0);  // R2 all ones
    run_boot(32'h2000_1000, 32'h0800_0201, 0, 1, 1'b1);  // R8 same-edge reset
    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [31:0] s, p;
      s = $urandom;
      p = $urandom;
      run_boot(s, p, int'($urandom % 4), int'($urandom % 4), ($urandom % 5) == 0);
    end
    summary();
    $finish;
  end

endmodule